// File: doc/BRIEF.md
# Dual Timer/Counter Peripheral

This block holds two independent timer/counter channels behind a byte-wide register bus. Software picks a counting mode per channel from a four-bit mode field. A channel can count 16 bits, count 13 bits (a 5-bit prescale feeding an 8-bit upper byte), or count 8 bits and reload from its high byte. Each channel also picks its source: the system clock divided by a fixed ratio (12 by default), or falling edges on its own external count pin. An optional level gate lets a second external pin hold the channel still while that pin is low.

A channel advances only while its run bit in the control register is set. When a channel wraps, hardware sets the channel's overflow flag. The flag stays set until software writes it to zero. The control register accepts byte writes and single-bit writes, so one run bit or one flag can change without a read-modify-write. Register reads come back combinationally on `sfr_rdata`.

This is register access, not a data stream, so every pin is a plain control or status pin. There is no valid/ready handshake and no back-pressure.

Top module: `dual_tmr_periph`

## Requirements
- R1: After reset, all six registers read 00H: control at 88H, mode at 89H, and the count bytes at 8AH to 8DH.
- R2: The register addresses are: control 88H, mode 89H, channel 0 low 8AH, channel 1 low 8BH, channel 0 high 8CH, channel 1 high 8DH. A byte write to any of them reads back unchanged while the channels are stopped. Bits 3..0 of the control register are plain storage.
- R3: A single-bit write (`bit_wr` with `bit_idx`, `bit_val`) changes only the addressed control bit.
- R4: While a channel's run bit is 0 (bit 4 for channel 0, bit 6 for channel 1), its count bytes do not change except by software writes.
- R5: With source select 0, a running channel advances exactly once per 12 system clocks.
- R6: With source select 1, a running channel advances once per falling edge on its count pin and never on a rising edge.
- R7: The gate bit is bit 3 of the channel's mode nibble. With the gate bit at 1, the channel advances only while its gate pin is high. With the gate bit at 0, the gate pin has no effect.
- R8: Mode bits 01 (nibble bits 1..0) join high:low into one 16-bit up-counter. The step from FFFFH to 0000H sets the overflow flag (control bit 5 for channel 0, bit 7 for channel 1).
- R9: Mode bits 10 count the low byte only. On leaving FFH, the low byte takes the high byte's value and the flag is set. The high byte is left unchanged.
- R10: Mode bits 00 count bits 4..0 of the low byte. Their carry increments the high byte, bits 7..5 of the low byte are left alone, and the step from high FFH with low bits 1FH sets the flag.
- R11: An overflow flag stays set until software writes it to 0. A hardware set in the same cycle as a software clear leaves the flag at 1.
- R12: A software write to a count byte in the same cycle as a hardware step wins.
- R13: Mode bits 11 hold the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_addr | input | 8 | Register address for reads and byte writes |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` |
| bit_wr | input | 1 | Single-bit write strobe for the control register |
| bit_idx | input | 3 | Control bit index for a single-bit write |
| bit_val | input | 1 | Value written by a single-bit write |
| ext_cnt | input | 2 | External count pins, one per channel |
| ext_gate | input | 2 | External gate pins, one per channel |

## Verification
The bench builds the block with the default divide ratio of 12 and a two-stage synchronizer.

- **Divide ratio.** With the ratio fixed at 12, any window of 12·K clocks holds exactly K prescaler ticks. The bench can therefore run a timer channel for a known number of steps without knowing the prescaler phase.
- **Synchronizer depth.** The two-stage synchronizer gives a fixed delay of three clock edges from a pin edge to the count step. That fixed delay lets the bench place a software count write, or a flag clear, on exactly the edge where a hardware step or overflow lands.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH = 2;
  localparam int CFG_W  = 4;

  typedef enum logic [1:0] {
    MD_13     = 2'b00,
    MD_16     = 2'b01,
    MD_RELOAD = 2'b10,
    MD_HOLD   = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] level
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pin;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign level = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  tmr_cfg_t          cfg,
  input  logic              tick,
  input  logic              ext_lvl,
  input  logic              gate_lvl,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf
);
  logic              ext_prev_q;
  logic              ext_fall;
  logic              step;
  logic [BYTE_W-1:0] lo_n, hi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= ext_lvl;
  end

  assign ext_fall = ext_prev_q & ~ext_lvl;
  assign step = run & (~cfg.gate | gate_lvl) & (cfg.ext_src ? ext_fall : tick);

  always_comb begin
    lo_n = cnt_lo;
    hi_n = cnt_hi;
    ovf  = 1'b0;
    if (step) begin
      unique case (cfg.mode)
        MD_13: begin
          if (&cnt_lo[PRE_W-1:0]) begin
            lo_n[PRE_W-1:0] = '0;
            hi_n = cnt_hi + 1'b1;
            ovf  = &cnt_hi;
          end else begin
            lo_n[PRE_W-1:0] = cnt_lo[PRE_W-1:0] + 1'b1;
          end
        end
        MD_16: begin
          {hi_n, lo_n} = {cnt_hi, cnt_lo} + 1'b1;
          ovf = &{cnt_hi, cnt_lo};
        end
        MD_RELOAD: begin
          if (&cnt_lo) begin
            lo_n = cnt_hi;
            ovf  = 1'b1;
          end else begin
            lo_n = cnt_lo + 1'b1;
          end
        end
        MD_HOLD: begin
        end
      endcase
    end
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_n;
      cnt_hi <= hi_n;
    end
  end
endmodule

// File: rtl/dual_tmr_periph.sv
module dual_tmr_periph
  import tmr_pkg::*;
#(
  parameter int         CLK_DIV     = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ADDR_CTL    = 8'h88,
  parameter logic [7:0] ADDR_MODE   = 8'h89,
  parameter logic [7:0] ADDR_LO     = 8'h8A,
  parameter logic [7:0] ADDR_HI     = 8'h8C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       bit_wr,
  input  logic [2:0] bit_idx,
  input  logic       bit_val,
  input  logic [1:0] ext_cnt,
  input  logic [1:0] ext_gate
);
  localparam int RUN_BIT0  = 4;
  localparam int FLAG_BIT0 = 5;

  logic [7:0]        mode_q;
  logic [7:0]        ctl_q, ctl_n;
  logic [7:0]        cnt_lo [NUM_CH];
  logic [7:0]        cnt_hi [NUM_CH];
  logic [NUM_CH-1:0] ovf;
  logic              tick;
  logic [2*NUM_CH-1:0] pin_lvl;

  tmr_prescale #(.DIV(CLK_DIV)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  tmr_sync #(.WIDTH(2*NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   ({ext_gate, ext_cnt}),
    .level (pin_lvl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [7:0] A_LO = ADDR_LO + 8'(g);
    localparam logic [7:0] A_HI = ADDR_HI + 8'(g);
    tmr_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctl_q[RUN_BIT0 + 2*g]),
      .cfg      (tmr_cfg_t'(mode_q[CFG_W*g +: CFG_W])),
      .tick     (tick),
      .ext_lvl  (pin_lvl[g]),
      .gate_lvl (pin_lvl[NUM_CH + g]),
      .wr_lo    (sfr_wr && (sfr_addr == A_LO)),
      .wr_hi    (sfr_wr && (sfr_addr == A_HI)),
      .wdata    (sfr_wdata),
      .cnt_lo   (cnt_lo[g]),
      .cnt_hi   (cnt_hi[g]),
      .ovf      (ovf[g])
    );
  end

  // Software first, then hardware overflow sets win over any clear.
  always_comb begin
    ctl_n = ctl_q;
    if (sfr_wr && (sfr_addr == ADDR_CTL)) ctl_n = sfr_wdata;
    if (bit_wr) ctl_n[bit_idx] = bit_val;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ovf[c]) ctl_n[FLAG_BIT0 + 2*c] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mode_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      if (sfr_wr && (sfr_addr == ADDR_MODE)) mode_q <= sfr_wdata;
    end
  end

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == ADDR_CTL)  sfr_rdata = ctl_q;
    if (sfr_addr == ADDR_MODE) sfr_rdata = mode_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sfr_addr == ADDR_LO + 8'(c)) sfr_rdata = cnt_lo[c];
      if (sfr_addr == ADDR_HI + 8'(c)) sfr_rdata = cnt_hi[c];
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sfr_wr,
  input logic [7:0] sfr_addr,
  input logic       bit_wr,
  input logic [2:0] bit_idx,
  input logic [1:0] mode0,
  input logic       run0,
  input logic       flag0,
  input logic [7:0] lo0,
  input logic [7:0] hi0
);
  logic        wr_cnt0;
  logic        wr_flag0;
  logic [15:0] cnt16;

  assign wr_cnt0  = sfr_wr && ((sfr_addr == 8'h8A) || (sfr_addr == 8'h8C));
  assign wr_flag0 = (sfr_wr && (sfr_addr == 8'h88)) || (bit_wr && (bit_idx == 3'd5));
  assign cnt16    = {hi0, lo0};

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !wr_cnt0) |=> ($stable(lo0) && $stable(hi0))); // R4
  AST_STEP16: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'b01 && !wr_cnt0) |=> (cnt16 == $past(cnt16) || cnt16 == $past(cnt16) + 16'd1)); // R8
  AST_WRAP16_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'b01 && !wr_cnt0 && cnt16 == 16'hFFFF) |=> (cnt16 == 16'hFFFF || flag0)); // R8
  AST_RELOAD_FROM_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'b10 && !wr_cnt0 && lo0 == 8'hFF) |=> (lo0 == 8'hFF || lo0 == $past(hi0))); // R9
  AST_RELOAD_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'b10 && !wr_cnt0) |=> $stable(hi0)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && !wr_flag0) |=> flag0); // R11
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'b11 && !wr_cnt0) |=> ($stable(lo0) && $stable(hi0))); // R13
endmodule

bind dual_tmr_periph tmr_checker u_tmr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .sfr_wr   (sfr_wr),
  .sfr_addr (sfr_addr),
  .bit_wr   (bit_wr),
  .bit_idx  (bit_idx),
  .mode0    (mode_q[1:0]),
  .run0     (ctl_q[4]),
  .flag0    (ctl_q[5]),
  .lo0      (cnt_lo[0]),
  .hi0      (cnt_hi[0])
);

// File: tb/test_dual_tmr_periph.sv
`timescale 1ns/1ps
module test_dual_tmr_periph;
  localparam int DIV = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       bit_wr = 1'b0;
  logic [2:0] bit_idx = 3'd0;
  logic       bit_val = 1'b0;
  logic [1:0] ext_cnt = 2'b11;
  logic [1:0] ext_gate = 2'b00;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_tmr_periph #(.CLK_DIV(DIV)) i_dual_tmr_periph (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .bit_wr(bit_wr),
    .bit_idx(bit_idx), .bit_val(bit_val), .ext_cnt(ext_cnt), .ext_gate(ext_gate)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    #1 d = sfr_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic bw(input int idx, input logic v);
    @(negedge clk);
    bit_wr = 1'b1; bit_idx = 3'(idx); bit_val = v;
    @(negedge clk);
    bit_wr = 1'b0;
  endtask

  task automatic pulse0(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_cnt[0] = 1'b0;
      repeat (4) @(negedge clk);
      ext_cnt[0] = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic cnt0(output logic [15:0] v);
    logic [7:0] h, l;
    rd(8'h8C, h);
    rd(8'h8A, l);
    v = {h, l};
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 8'h88; a <= 8'h8D; a++) begin
      rd(8'(a), d);
      chk("R1 reset value", {8'h00, d}, 16'h0000);
    end
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(8'h89, 8'h5A); rd(8'h89, d); chk("R2 mode reg", {8'h0, d}, 16'h005A);
    wr(8'h8A, 8'h11); wr(8'h8B, 8'h22); wr(8'h8C, 8'h33); wr(8'h8D, 8'h44);
    rd(8'h8A, d); chk("R2 ch0 low", {8'h0, d}, 16'h0011);
    rd(8'h8B, d); chk("R2 ch1 low", {8'h0, d}, 16'h0022);
    rd(8'h8C, d); chk("R2 ch0 high", {8'h0, d}, 16'h0033);
    rd(8'h8D, d); chk("R2 ch1 high", {8'h0, d}, 16'h0044);
    wr(8'h88, 8'h0A); rd(8'h88, d); chk("R2 ctl storage", {8'h0, d}, 16'h000A);
  endtask

  task automatic t_bitops();
    logic [7:0] d;
    wr(8'h88, 8'h0F);
    bw(7, 1'b1); rd(8'h88, d); chk("R3 set bit 7", {8'h0, d}, 16'h008F);
    bw(1, 1'b0); rd(8'h88, d); chk("R3 clear bit 1", {8'h0, d}, 16'h008D);
    wr(8'h88, 8'h00);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(8'h89, 8'h05); wr(8'h8A, 8'h00); wr(8'h8C, 8'h00);
    pulse0(3);
    cnt0(v); chk("R4 stopped channel holds", v, 16'h0000);
  endtask

  task automatic t_event();
    logic [15:0] v;
    bw(4, 1'b1);
    pulse0(3);
    cnt0(v); chk("R6 three falling edges", v, 16'h0003);
    @(negedge clk) ext_cnt[0] = 1'b0;
    repeat (6) @(negedge clk);
    cnt0(v); chk("R6 low level counts once", v, 16'h0004);
    @(negedge clk) ext_cnt[0] = 1'b1;
    repeat (6) @(negedge clk);
    cnt0(v); chk("R6 rising edge ignored", v, 16'h0004);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    wr(8'h89, 8'h0D); wr(8'h8A, 8'h00); wr(8'h8C, 8'h00);
    ext_gate[0] = 1'b0; repeat (4) @(negedge clk);
    pulse0(2);
    cnt0(v); chk("R7 gate low blocks", v, 16'h0000);
    ext_gate[0] = 1'b1; repeat (4) @(negedge clk);
    pulse0(2);
    cnt0(v); chk("R7 gate high passes", v, 16'h0002);
    wr(8'h89, 8'h05);
    ext_gate[0] = 1'b0; repeat (4) @(negedge clk);
    pulse0(1);
    cnt0(v); chk("R7 gate bit 0 ignores pin", v, 16'h0003);
  endtask

  task automatic t_timer16();
    logic [7:0] h, l, c;
    wr(8'h89, 8'h10); wr(8'h8D, 8'hFF); wr(8'h8B, 8'hF0);
    @(negedge clk); bit_wr = 1'b1; bit_idx = 3'd6; bit_val = 1'b1;
    @(negedge clk); bit_wr = 1'b0;
    repeat (20*DIV - 1) @(negedge clk);
    bit_wr = 1'b1; bit_idx = 3'd6; bit_val = 1'b0;
    @(negedge clk); bit_wr = 1'b0;
    rd(8'h8D, h); rd(8'h8B, l);
    chk("R5 twenty ticks in 240 clocks, R8 wrap", {h, l}, 16'h0004);
    rd(8'h88, c); chk("R8 ch1 flag set", {15'h0, c[7]}, 16'h0001);
    repeat (20) @(negedge clk);
    rd(8'h88, c); chk("R11 flag sticky", {15'h0, c[7]}, 16'h0001);
    bw(7, 1'b0);
    rd(8'h88, c); chk("R11 software clear", {15'h0, c[7]}, 16'h0000);
  endtask

  task automatic t_reload();
    logic [7:0] h, l, c;
    wr(8'h89, 8'h06); wr(8'h8C, 8'hFD); wr(8'h8A, 8'hFE);
    pulse0(3);
    rd(8'h8C, h); rd(8'h8A, l);
    chk("R9 reload from high", {h, l}, 16'hFDFE);
    rd(8'h88, c); chk("R9 flag set", {15'h0, c[5]}, 16'h0001);
    bw(5, 1'b0);
  endtask

  task automatic t_mode13();
    logic [15:0] v;
    logic [7:0] c;
    wr(8'h89, 8'h04); wr(8'h8C, 8'hFF); wr(8'h8A, 8'hFE);
    pulse0(1);
    cnt0(v); chk("R10 prescale step", v, 16'hFFFF);
    pulse0(1);
    cnt0(v); chk("R10 13-bit wrap keeps low bits 7..5", v, 16'h00E0);
    rd(8'h88, c); chk("R10 flag set", {15'h0, c[5]}, 16'h0001);
    bw(5, 1'b0);
    wr(8'h8C, 8'h41); wr(8'h8A, 8'h1F);
    pulse0(1);
    cnt0(v); chk("R10 carry into high", v, 16'h4200);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    wr(8'h89, 8'h07); wr(8'h8C, 8'h12); wr(8'h8A, 8'h34);
    pulse0(2);
    cnt0(v); chk("R13 mode 11 holds", v, 16'h1234);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    logic [7:0] c;
    wr(8'h89, 8'h05); wr(8'h8C, 8'h00); wr(8'h8A, 8'h10);
    @(negedge clk) ext_cnt[0] = 1'b0;
    repeat (2) @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = 8'h8A; sfr_wdata = 8'h55;
    @(negedge clk); sfr_wr = 1'b0; ext_cnt[0] = 1'b1;
    repeat (4) @(negedge clk);
    cnt0(v); chk("R12 write beats step", v, 16'h0055);
    wr(8'h8C, 8'hFF); wr(8'h8A, 8'hFF);
    @(negedge clk) ext_cnt[0] = 1'b0;
    repeat (2) @(negedge clk);
    bit_wr = 1'b1; bit_idx = 3'd5; bit_val = 1'b0;
    @(negedge clk); bit_wr = 1'b0; ext_cnt[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h88, c); chk("R11 set beats clear", {15'h0, c[5]}, 16'h0001);
    cnt0(v); chk("R8 wrap to zero", v, 16'h0000);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regmap();
    t_bitops();
    t_stop();
    t_event();
    t_gate();
    t_timer16();
    t_reload();
    t_mode13();
    t_hold();
    t_collide();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end
endmodule